// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a small 8-bit machine. It reads 16-bit instruction words from a 64-word program store outside the block. Each word splits into an opcode in bits 15:12, a first operand selector in bits 11:9, a second operand selector in bits 8:6, and a 6-bit absolute branch target in bits 5:0. Two register files of eight bytes each sit inside the block. The special file feeds the ALU operands, two output bytes and four display coordinates. The general file holds working values.

Every instruction occupies a fixed window of four clock cycles. An ALU instruction gets six extra cycles, so its window is ten cycles. Its first cycle latches the word. Side-effect strobes fire in the second cycle. All writes and the program-counter update land on the final cycle. The ALU, the display engine, the constant ROM and the random source are all outside the block. It reaches them through plain strobe or level signals.

Two opcodes can stretch the final cycle. A wait holds there until a resume input is seen. A display command holds there while the display reports busy. An end opcode freezes the sequencer until reset.

Top module: `seq16_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving it, the sequencer is in its reset state. In that state pmem_addr is 0, halted is 0, indicator is 0, and all special and general registers read 0.
- R2: Every opcode except 0101 takes exactly 4 cycles from fetch to program-counter update, unless it is stretched by R9 or R10.
- R3: Opcode 0101 takes 10 cycles. It raises alu_req for exactly one cycle, with alu_op equal to the first selector, alu_a equal to special register 0 and alu_b equal to special register 1. On its final cycle it writes alu_result into general register [second selector] and latches alu_carry, alu_uflow and alu_oflow.
- R4: Opcode 0001 copies general [first] into special [second]. Opcode 0011 copies general [first] into general [second]. Opcode 0010 clears general [first]. Special registers map as follows: 0 drives alu_a, 1 drives alu_b, 2 drives out0, 3 drives out1, and 4 to 7 drive disp_x0, disp_y0, disp_x1 and disp_y1.
- R5: Opcode 0000 branches to bits 5:0 when the condition chosen by the first selector holds. The conditions are: 0 always; 1 carry flag; 2 underflow flag; 3 overflow flag; 4 A==B; 5 A>B; 6 B>A; 7 A!=B. A and B are special registers 0 and 1, compared unsigned.
- R6: When no branch is taken, the program counter increments, and it wraps from 63 to 0.
- R7: Opcode 1001 writes rom_data into general [second], with rom_addr equal to the first selector. Opcode 0110 writes user_data there, and opcode 1000 writes rng_data there.
- R8: Opcode 0100 inverts indicator bit [first selector] and leaves the other bits unchanged.
- R9: Opcode 0111 holds on its final cycle until resume is sampled high, then advances.
- R10: Opcodes 1010 to 1110 pulse disp_strobe for one cycle in their second cycle, with disp_cmd equal to the opcode minus 1010 (0 to 4). They then hold on the final cycle while disp_busy is high.
- R11: Opcode 1111 raises halted. After that, pmem_addr and all registers stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmem_addr | output | 6 | Program counter / program store address |
| pmem_data | input | 16 | Instruction word at pmem_addr |
| rom_addr | output | 3 | Constant ROM address (first selector) |
| rom_data | input | 8 | Constant ROM data |
| user_data | input | 8 | User input byte |
| rng_data | input | 8 | Random source byte |
| resume | input | 1 | Releases a wait instruction |
| alu_req | output | 1 | One-cycle ALU request |
| alu_op | output | 3 | ALU operation select |
| alu_a | output | 8 | ALU operand A |
| alu_b | output | 8 | ALU operand B |
| alu_result | input | 8 | ALU result |
| alu_carry | input | 1 | ALU carry flag |
| alu_uflow | input | 1 | ALU shift underflow flag |
| alu_oflow | input | 1 | ALU shift overflow flag |
| disp_strobe | output | 1 | Display command strobe |
| disp_cmd | output | 3 | Display command code |
| disp_busy | input | 1 | Display engine busy |
| disp_x0 | output | 8 | Display corner X0 |
| disp_y0 | output | 8 | Display corner Y0 |
| disp_x1 | output | 8 | Display corner X1 |
| disp_y1 | output | 8 | Display corner Y1 |
| out0 | output | 8 | Output byte 0 |
| out1 | output | 8 | Output byte 1 |
| indicator | output | 8 | Indicator lamps |
| halted | output | 1 | Program has ended |

## Verification
The bench runs every ALU operation on two operand pairs. It runs every branch condition against three flag and comparison scenarios, including equal operands and B greater than A. These runs expose a swapped condition code or an unsigned compare done backwards, either of which sends a program down the wrong path. The total cycle count of each program is checked. A design that miscounts the ten-cycle ALU window, or that stretches a display command by the wrong amount, fails these counts. Further programs cover a branch to 62 that runs through the 63-to-0 wrap, a wait held for twenty cycles before resume, and five back-to-back display commands with a busy stub. A wrap bug lands on the wrong address. A wait or busy bug either runs ahead or never ends.

// File: rtl/seq16_pkg.sv
package seq16_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int SEL_W   = 3;
  localparam int TGT_W   = 6;

  typedef enum logic [OPC_W-1:0] {
    OP_BRANCH = 4'd0,  OP_G2S  = 4'd1,  OP_CLR   = 4'd2,  OP_G2G  = 4'd3,
    OP_TOGGLE = 4'd4,  OP_ALU  = 4'd5,  OP_INPUT = 4'd6,  OP_WAIT = 4'd7,
    OP_RANDOM = 4'd8,  OP_ROM  = 4'd9,  OP_DRAW  = 4'd10, OP_FILLX = 4'd11,
    OP_FILL   = 4'd12, OP_FILLY = 4'd13, OP_WIPE = 4'd14, OP_END  = 4'd15
  } opcode_e;

  typedef enum logic [SEL_W-1:0] {
    C_ALWAYS = 3'd0, C_CARRY = 3'd1, C_UFLOW = 3'd2, C_OFLOW = 3'd3,
    C_EQ     = 3'd4, C_AGT   = 3'd5, C_BGT   = 3'd6, C_NE    = 3'd7
  } cond_e;

  // Instruction window length in cycles.
  function automatic int unsigned op_cycles(opcode_e op, int unsigned base, int unsigned extra);
    return (op == OP_ALU) ? base + extra : base;
  endfunction

  function automatic logic is_display(opcode_e op);
    return (op >= OP_DRAW) && (op <= OP_WIPE);
  endfunction

  function automatic logic [SEL_W-1:0] display_code(opcode_e op);
    logic [OPC_W-1:0] d;
    d = OPC_W'(op) - OPC_W'(OP_DRAW);
    return d[SEL_W-1:0];
  endfunction

  // Opcodes that write the general register file.
  function automatic logic writes_gpr(opcode_e op);
    return (op == OP_CLR) || (op == OP_G2G) || (op == OP_ALU) ||
           (op == OP_INPUT) || (op == OP_RANDOM) || (op == OP_ROM);
  endfunction

endpackage

// File: rtl/seq16_regs.sv
module seq16_regs #(
  parameter int W  = 8,
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [W-1:0]        wdata,
  input  logic [AW-1:0]       raddr,
  output logic [W-1:0]        rdata,
  output logic [N-1:0][W-1:0] q_all
);

  logic [N-1:0][W-1:0] mem;

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[i] <= '0;
      else if (we && (waddr == AW'(i)))    mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign q_all = mem;

endmodule

// File: rtl/seq16_decode.sv
module seq16_decode
  import seq16_pkg::*;
#(
  parameter int BASE_CYC  = 4,
  parameter int ALU_EXTRA = 6,
  parameter int PH_W      = 4
) (
  input  logic [INSTR_W-1:0] instr,
  output opcode_e            op,
  output logic [SEL_W-1:0]   sel1,
  output logic [SEL_W-1:0]   sel2,
  output logic [TGT_W-1:0]   tgt,
  output logic [PH_W-1:0]    last_ph,
  output logic               is_alu,
  output logic               is_disp,
  output logic               is_wait,
  output logic               is_end,
  output logic               is_branch,
  output logic               is_toggle,
  output logic               is_g2s,
  output logic               gpr_we_kind
);

  assign op   = opcode_e'(instr[INSTR_W-1 -: OPC_W]);
  assign sel1 = instr[INSTR_W-OPC_W-1 -: SEL_W];
  assign sel2 = instr[INSTR_W-OPC_W-SEL_W-1 -: SEL_W];
  assign tgt  = instr[TGT_W-1:0];

  assign last_ph     = PH_W'(op_cycles(op, BASE_CYC, ALU_EXTRA) - 1);
  assign is_alu      = (op == OP_ALU);
  assign is_disp     = is_display(op);
  assign is_wait     = (op == OP_WAIT);
  assign is_end      = (op == OP_END);
  assign is_branch   = (op == OP_BRANCH);
  assign is_toggle   = (op == OP_TOGGLE);
  assign is_g2s      = (op == OP_G2S);
  assign gpr_we_kind = writes_gpr(op);

endmodule

// File: rtl/seq16_cond.sv
module seq16_cond
  import seq16_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [SEL_W-1:0]  cond,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              f_carry,
  input  logic              f_uflow,
  input  logic              f_oflow,
  output logic              take
);

  always_comb begin
    unique case (cond_e'(cond))
      C_ALWAYS: take = 1'b1;
      C_CARRY:  take = f_carry;
      C_UFLOW:  take = f_uflow;
      C_OFLOW:  take = f_oflow;
      C_EQ:     take = (a == b);
      C_AGT:    take = (a > b);
      C_BGT:    take = (b > a);
      C_NE:     take = (a != b);
      default:  take = 1'b0;
    endcase
  end

endmodule

// File: rtl/seq16_ctrl.sv
module seq16_ctrl
  import seq16_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BASE_CYC  = 4,
  parameter int ALU_EXTRA = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [5:0]        pmem_addr,
  input  logic [15:0]       pmem_data,
  output logic [2:0]        rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  input  logic [DATA_W-1:0] user_data,
  input  logic [DATA_W-1:0] rng_data,
  input  logic              resume,
  output logic              alu_req,
  output logic [2:0]        alu_op,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_uflow,
  input  logic              alu_oflow,
  output logic              disp_strobe,
  output logic [2:0]        disp_cmd,
  input  logic              disp_busy,
  output logic [DATA_W-1:0] disp_x0,
  output logic [DATA_W-1:0] disp_y0,
  output logic [DATA_W-1:0] disp_x1,
  output logic [DATA_W-1:0] disp_y1,
  output logic [DATA_W-1:0] out0,
  output logic [DATA_W-1:0] out1,
  output logic [DATA_W-1:0] indicator,
  output logic              halted
);

  localparam int PH_W   = $clog2(BASE_CYC + ALU_EXTRA);
  localparam int NREG   = 1 << SEL_W;
  localparam int IND_W  = DATA_W;

  // Architectural state
  logic [INSTR_W-1:0] ir;
  logic [PH_W-1:0]    ph;
  logic [TGT_W-1:0]   pc;
  logic               halted_q;
  logic               f_carry, f_uflow, f_oflow;
  logic [IND_W-1:0]   ind_q;

  // Decode
  opcode_e          op;
  logic [SEL_W-1:0] sel1, sel2;
  logic [TGT_W-1:0] tgt;
  logic [PH_W-1:0]  last_ph;
  logic dec_alu, dec_disp, dec_wait, dec_end, dec_branch, dec_toggle, dec_g2s, dec_gwr;

  seq16_decode #(.BASE_CYC(BASE_CYC), .ALU_EXTRA(ALU_EXTRA), .PH_W(PH_W)) u_dec (
    .instr(ir), .op(op), .sel1(sel1), .sel2(sel2), .tgt(tgt), .last_ph(last_ph),
    .is_alu(dec_alu), .is_disp(dec_disp), .is_wait(dec_wait), .is_end(dec_end),
    .is_branch(dec_branch), .is_toggle(dec_toggle), .is_g2s(dec_g2s),
    .gpr_we_kind(dec_gwr)
  );

  // Named sequencing events
  logic in_exec, at_last, wait_stall, disp_stall, instr_done, jump_taken, cond_true;
  logic [TGT_W-1:0] pc_next;

  assign in_exec    = !halted_q && (ph != '0);
  assign at_last    = in_exec && (ph == last_ph);
  assign wait_stall = at_last && dec_wait && !resume;
  assign disp_stall = at_last && dec_disp && disp_busy;
  assign instr_done = at_last && !wait_stall && !disp_stall;
  assign jump_taken = dec_branch && cond_true;
  assign pc_next    = dec_end ? pc : (jump_taken ? tgt : pc + 1'b1);

  // Register files
  logic [NREG-1:0][DATA_W-1:0] spr_q, gpr_q;
  logic [DATA_W-1:0] gpr_rd, gpr_wd, spr_rd_unused;
  logic              gpr_we, spr_we;
  logic [SEL_W-1:0]  gpr_wa;

  assign gpr_we = instr_done && dec_gwr;
  assign gpr_wa = (op == OP_CLR) ? sel1 : sel2;
  assign spr_we = instr_done && dec_g2s;

  always_comb begin
    unique case (op)
      OP_CLR:    gpr_wd = '0;
      OP_G2G:    gpr_wd = gpr_rd;
      OP_ALU:    gpr_wd = alu_result;
      OP_INPUT:  gpr_wd = user_data;
      OP_RANDOM: gpr_wd = rng_data;
      OP_ROM:    gpr_wd = rom_data;
      default:   gpr_wd = '0;
    endcase
  end

  seq16_regs #(.W(DATA_W), .N(NREG)) u_gpr (
    .clk(clk), .rst_n(rst_n), .we(gpr_we), .waddr(gpr_wa), .wdata(gpr_wd),
    .raddr(sel1), .rdata(gpr_rd), .q_all(gpr_q)
  );

  seq16_regs #(.W(DATA_W), .N(NREG)) u_spr (
    .clk(clk), .rst_n(rst_n), .we(spr_we), .waddr(sel2), .wdata(gpr_rd),
    .raddr(sel1), .rdata(spr_rd_unused), .q_all(spr_q)
  );

  seq16_cond #(.DATA_W(DATA_W)) u_cond (
    .cond(sel1), .a(spr_q[0]), .b(spr_q[1]),
    .f_carry(f_carry), .f_uflow(f_uflow), .f_oflow(f_oflow), .take(cond_true)
  );

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir       <= '0;
      ph       <= '0;
      pc       <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (ph == '0) begin
        ir <= pmem_data;
        ph <= PH_W'(1);
      end else if (instr_done) begin
        ph <= '0;
        pc <= pc_next;
        if (dec_end) halted_q <= 1'b1;
      end else if (!(wait_stall || disp_stall)) begin
        ph <= ph + 1'b1;
      end
    end
  end

  // Flags and indicator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_carry <= 1'b0;
      f_uflow <= 1'b0;
      f_oflow <= 1'b0;
      ind_q   <= '0;
    end else if (instr_done) begin
      if (dec_alu) begin
        f_carry <= alu_carry;
        f_uflow <= alu_uflow;
        f_oflow <= alu_oflow;
      end
      if (dec_toggle) ind_q[sel1] <= ~ind_q[sel1];
    end
  end

  // Outputs
  assign pmem_addr   = pc;
  assign rom_addr    = sel1;
  assign alu_req     = in_exec && (ph == PH_W'(1)) && dec_alu;
  assign alu_op      = sel1;
  assign alu_a       = spr_q[0];
  assign alu_b       = spr_q[1];
  assign disp_strobe = in_exec && (ph == PH_W'(1)) && dec_disp;
  assign disp_cmd    = dec_disp ? display_code(op) : '0;
  assign out0        = spr_q[2];
  assign out1        = spr_q[3];
  assign disp_x0     = spr_q[4];
  assign disp_y0     = spr_q[5];
  assign disp_x1     = spr_q[6];
  assign disp_y1     = spr_q[7];
  assign indicator   = ind_q;
  assign halted      = halted_q;

  logic unused_ok;
  assign unused_ok = ^{spr_rd_unused, gpr_q};

endmodule

// File: rtl/seq16_ctrl_chk.sv
module seq16_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        pmem_addr,
  input logic              halted,
  input logic              instr_done,
  input logic              jump_taken,
  input logic              dec_end,
  input logic              dec_toggle,
  input logic [5:0]        tgt,
  input logic              wait_stall,
  input logic              alu_req,
  input logic              disp_strobe,
  input logic [2:0]        disp_cmd,
  input logic [DATA_W-1:0] indicator
);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (pmem_addr == 6'd0 && !halted && indicator == '0));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(pmem_addr));

  assert_alu_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alu_req |=> !alu_req);

  assert_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && jump_taken) |=> (pmem_addr == $past(tgt)));

  assert_increment_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && !jump_taken && !dec_end) |=> (pmem_addr == 6'($past(pmem_addr) + 6'd1)));

  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && dec_toggle) |=> ($countones(indicator ^ $past(indicator)) == 1));

  assert_ind_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_done && dec_toggle) |=> $stable(indicator));

  assert_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_stall |=> ($stable(pmem_addr) && !halted));

  assert_disp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_strobe |=> !disp_strobe);

  assert_disp_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_strobe |-> (disp_cmd <= 3'd4));

  assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pmem_addr) && $stable(indicator)));

endmodule

bind seq16_ctrl seq16_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .halted(halted),
  .instr_done(instr_done), .jump_taken(jump_taken), .dec_end(dec_end),
  .dec_toggle(dec_toggle), .tgt(tgt), .wait_stall(wait_stall),
  .alu_req(alu_req), .disp_strobe(disp_strobe), .disp_cmd(disp_cmd),
  .indicator(indicator)
);

// File: tb/sim_seq16_ctrl.sv
module sim_seq16_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0]  pmem_addr;
  logic [15:0] pmem_data;
  logic [2:0]  rom_addr;
  logic [7:0]  rom_data, user_data, rng_data;
  logic        resume;
  logic        alu_req, alu_carry, alu_uflow, alu_oflow;
  logic [2:0]  alu_op;
  logic [7:0]  alu_a, alu_b, alu_result;
  logic        disp_strobe, disp_busy;
  logic [2:0]  disp_cmd;
  logic [7:0]  disp_x0, disp_y0, disp_x1, disp_y1, out0, out1, indicator;
  logic        halted;

  logic [15:0] prog [64];
  logic [7:0]  rom  [8];

  assign pmem_data = prog[pmem_addr];
  assign rom_data  = rom[rom_addr];

  seq16_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_data(pmem_data),
    .rom_addr(rom_addr), .rom_data(rom_data), .user_data(user_data),
    .rng_data(rng_data), .resume(resume), .alu_req(alu_req), .alu_op(alu_op),
    .alu_a(alu_a), .alu_b(alu_b), .alu_result(alu_result), .alu_carry(alu_carry),
    .alu_uflow(alu_uflow), .alu_oflow(alu_oflow), .disp_strobe(disp_strobe),
    .disp_cmd(disp_cmd), .disp_busy(disp_busy), .disp_x0(disp_x0),
    .disp_y0(disp_y0), .disp_x1(disp_x1), .disp_y1(disp_y1), .out0(out0),
    .out1(out1), .indicator(indicator), .halted(halted)
  );

  // ALU stub
  always_comb begin
    logic [8:0] s;
    s = 9'd0;
    alu_carry = 1'b0; alu_uflow = 1'b0; alu_oflow = 1'b0;
    case (alu_op)
      3'd0: begin s = {1'b0, alu_a} + {1'b0, alu_b}; alu_result = s[7:0]; alu_carry = s[8]; end
      3'd1: alu_result = alu_a - alu_b;
      3'd2: begin alu_result = alu_a >> 1; alu_uflow = alu_a[0]; alu_oflow = alu_a[7]; end
      3'd3: begin s = {1'b0, alu_a} + 9'd1; alu_result = s[7:0]; alu_carry = s[8]; end
      3'd4: alu_result = alu_a ^ alu_b;
      3'd5: alu_result = ~(alu_a ^ alu_b);
      3'd6: alu_result = alu_a & alu_b;
      default: alu_result = alu_a | alu_b;
    endcase
  end

  // Display busy stub: busy for BUSY_LEN cycles after a strobe
  localparam int BUSY_LEN = 3;
  int busy_cnt;
  assign disp_busy = (busy_cnt != 0);

  int cyc, alu_cnt, scnt;
  logic [2:0] slog [8];
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0; alu_cnt <= 0; scnt <= 0; busy_cnt <= 0;
    end else begin
      cyc <= cyc + 1;
      if (alu_req) alu_cnt <= alu_cnt + 1;
      if (disp_strobe) begin
        if (scnt < 8) slog[scnt] <= disp_cmd;
        scnt <= scnt + 1;
        busy_cnt <= BUSY_LEN;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int s1, input int s2, input int t);
    return {op[3:0], s1[2:0], s2[2:0], t[5:0]};
  endfunction

  function automatic int exp_alu(input int op, input int a, input int b);
    case (op)
      0: return (a + b) % 256;
      1: return (a - b + 256) % 256;
      2: return a / 2;
      3: return (a + 1) % 256;
      4: return a ^ b;
      5: return 255 - (a ^ b);
      6: return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic int exp_take(input int cond, input int a, input int b, input int op);
    int c, u, o;
    c = ((op == 0) && (a + b > 255)) || ((op == 3) && (a == 255));
    u = (op == 2) && (a % 2 == 1);
    o = (op == 2) && (a >= 128);
    case (cond)
      0: return 1;
      1: return c;
      2: return u;
      3: return o;
      4: return a == b;
      5: return a > b;
      6: return b > a;
      default: return a != b;
    endcase
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = enc(15, 0, 0, 0);
  endtask

  task automatic start();
    rst_n = 1'b0;
    resume = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_halt(input int limit);
    int n;
    n = 0;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  int ta, tb, oa;

  initial begin
    user_data = 8'hA5;
    rng_data  = 8'h5C;
    resume    = 1'b0;
    for (int i = 0; i < 8; i++) rom[i] = 8'(16 * i + 3);

    // R1: reset state
    clear_prog();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pmem_addr", pmem_addr, 0);
    chk("R1 halted", halted, 0);
    chk("R1 indicator", indicator, 0);
    chk("R1 out0", out0, 0);
    chk("R1 alu_a", alu_a, 0);
    chk("R1 disp_x1", disp_x1, 0);

    // R7/R4: ROM and input loads, moves to outputs
    clear_prog();
    prog[0] = enc(9, 3, 1, 0);
    prog[1] = enc(6, 0, 2, 0);
    prog[2] = enc(1, 1, 2, 0);
    prog[3] = enc(1, 2, 3, 0);
    prog[4] = enc(15, 0, 0, 0);
    start(); run_halt(200);
    chk("R7 rom load", out0, 16 * 3 + 3);
    chk("R7 input load", out1, 8'hA5);
    chk("R2 cycles 5 base", cyc, 20);

    // R7/R4: random, copy, clear
    clear_prog();
    prog[0] = enc(8, 0, 3, 0);
    prog[1] = enc(3, 3, 4, 0);
    prog[2] = enc(1, 4, 2, 0);
    prog[3] = enc(2, 3, 0, 0);
    prog[4] = enc(1, 3, 3, 0);
    prog[5] = enc(15, 0, 0, 0);
    start(); run_halt(200);
    chk("R7 random via copy R4", out0, 8'h5C);
    chk("R4 clear", out1, 0);
    chk("R2 cycles 6 base", cyc, 24);

    // R3: ALU sweep
    for (int pair = 0; pair < 2; pair++) begin
      ta = (pair == 0) ? 200 : 13;
      tb = (pair == 0) ? 100 : 250;
      for (int op = 0; op < 8; op++) begin
        rom[1] = 8'(ta); rom[2] = 8'(tb);
        clear_prog();
        prog[0] = enc(9, 1, 1, 0);
        prog[1] = enc(9, 2, 2, 0);
        prog[2] = enc(1, 1, 0, 0);
        prog[3] = enc(1, 2, 1, 0);
        prog[4] = enc(5, op, 5, 0);
        prog[5] = enc(1, 5, 2, 0);
        prog[6] = enc(15, 0, 0, 0);
        start(); run_halt(300);
        chk($sformatf("R3 alu op%0d pair%0d", op, pair), out0, exp_alu(op, ta, tb));
        chk("R3 alu window cycles", cyc, 34);
        chk("R3 single alu_req", alu_cnt, 1);
      end
    end

    // R5: branch condition sweep
    for (int ds = 0; ds < 3; ds++) begin
      case (ds)
        0: begin ta = 201; tb = 100; oa = 2; end
        1: begin ta = 50;  tb = 50;  oa = 0; end
        default: begin ta = 10; tb = 250; oa = 0; end
      endcase
      for (int cond = 0; cond < 8; cond++) begin
        rom[1] = 8'(ta); rom[2] = 8'(tb); rom[3] = 8'h33; rom[4] = 8'h44;
        clear_prog();
        prog[0]  = enc(9, 1, 1, 0);
        prog[1]  = enc(9, 2, 2, 0);
        prog[2]  = enc(1, 1, 0, 0);
        prog[3]  = enc(1, 2, 1, 0);
        prog[4]  = enc(5, oa, 6, 0);
        prog[5]  = enc(0, cond, 0, 10);
        prog[6]  = enc(9, 3, 7, 0);
        prog[7]  = enc(1, 7, 2, 0);
        prog[8]  = enc(15, 0, 0, 0);
        prog[10] = enc(9, 4, 7, 0);
        prog[11] = enc(1, 7, 2, 0);
        prog[12] = enc(15, 0, 0, 0);
        start(); run_halt(300);
        chk($sformatf("R5 cond%0d set%0d", cond, ds), out0,
            exp_take(cond, ta, tb, oa) ? 8'h44 : 8'h33);
        chk("R5 branch path cycles", cyc, 42);
      end
    end

    // R6: wrap from 63 to 0
    for (int i = 0; i < 8; i++) rom[i] = 8'(16 * i + 3);
    clear_prog();
    prog[0]  = enc(0, 7, 0, 5);
    prog[1]  = enc(9, 1, 1, 0);
    prog[2]  = enc(1, 1, 0, 0);
    prog[3]  = enc(0, 0, 0, 62);
    prog[62] = enc(9, 2, 2, 0);
    prog[63] = enc(1, 2, 2, 0);
    prog[5]  = enc(15, 0, 0, 0);
    start(); run_halt(300);
    chk("R6 wrap reached end", pmem_addr, 5);
    chk("R6 wrap path value", out0, 16 * 2 + 3);
    chk("R6 wrap cycles", cyc, 32);

    // R11: frozen after end
    repeat (10) @(negedge clk);
    chk("R11 halted held", halted, 1);
    chk("R11 pc held", pmem_addr, 5);
    chk("R11 out0 held", out0, 16 * 2 + 3);

    // R8: indicator toggles
    clear_prog();
    prog[0] = enc(4, 3, 0, 0);
    prog[1] = enc(4, 5, 0, 0);
    prog[2] = enc(4, 3, 0, 0);
    prog[3] = enc(4, 0, 0, 0);
    start(); run_halt(200);
    chk("R8 indicator", indicator, 8'b0010_0001);

    // R9: wait until resume
    clear_prog();
    prog[0] = enc(7, 0, 0, 0);
    prog[1] = enc(9, 1, 1, 0);
    prog[2] = enc(1, 1, 2, 0);
    start();
    repeat (20) @(negedge clk);
    chk("R9 stalled pc", pmem_addr, 0);
    chk("R9 stalled out0", out0, 0);
    chk("R9 not halted", halted, 0);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    run_halt(200);
    chk("R9 released", out0, 16 * 1 + 3);

    // R10: display commands with busy stretch
    clear_prog();
    prog[0] = enc(9, 1, 1, 0);
    prog[1] = enc(1, 1, 4, 0);
    prog[2] = enc(9, 2, 2, 0);
    prog[3] = enc(1, 2, 7, 0);
    for (int k = 0; k < 5; k++) prog[4 + k] = enc(10 + k, 0, 0, 0);
    prog[9] = enc(15, 0, 0, 0);
    start(); run_halt(400);
    chk("R10 strobe count", scnt, 5);
    for (int k = 0; k < 5; k++) chk($sformatf("R10 code %0d", k), slog[k], k);
    chk("R4 disp_x0", disp_x0, 16 * 1 + 3);
    chk("R4 disp_y1", disp_y1, 16 * 2 + 3);
    chk("R10 busy stretch cycles", cyc, 16 + 5 * (BUSY_LEN + 3) + 4);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule